// File: doc/BRIEF.md
# Three-Bank Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt lines, held as three banks of 32, and presents them to a processor as two outputs: a normal interrupt and a fast interrupt. Every line has a 6-bit priority and a steering bit that picks its class. Each bank keeps a raw input view, a mask with atomic set and clear aliases, software-forced pending bits that live alongside the hardware inputs, and two filtered pending views, one per class.

Software talks to the block through a 32-bit word-access register port with a 12-bit byte address. Reads are combinational and have no side effects. Each class has an arming flag. While the flag is set and some unmasked line of that class is pending, the block latches the number of the winning line, raises the output, and disarms. Software reads the latched line number, services the source, and then writes a re-arm bit in the control register. A global mask bit stops any new output assertion. A soft reset bit returns all state to its reset values. An autoidle bit and a 2-bit idle field are plain storage.

Top module: `lvl_intc`

## Requirements
- R1: After reset every mask bit is 1 and all pending, software and input bits are 0. Both outputs are low, both latched codes are 0, the global mask is 0, and both classes are armed. Address 0x000 reads 0x21 and address 0x014 reads 1.
- R2: A line's raw state is sampled on each clock edge. Bank b has its block base at 0x080 + 0x20·b. Offset +0x00 of that base reads the sampled inputs, with bit i standing for line 32·b + i. A 0-to-1 transition of a line sets its pending bit at the same edge.
- R3: On any edge where at least one line of a bank goes from 1 to 0, that bank's pending vector becomes the new input vector OR the bank's software bits.
- R4: A write to +0x10 ORs the data into both the software bits and the pending bits. A write to +0x14 clears the written bits from the software bits, and pending then becomes the remaining software bits AND the sampled inputs. Offset +0x10 reads the software bits.
- R5: Offset +0x04 writes and reads the mask. A write to +0x08 clears the written mask bits and a write to +0x0C sets them. Both aliases read 0.
- R6: Offset +0x18 reads pending AND NOT mask AND NOT steer. Offset +0x1C reads pending AND NOT mask AND steer.
- R7: The line register for line n sits at 0x100 + 4·n, for n from 0 to 95. It holds the priority in bits [7:2] and the steering bit in bit 0, where 1 selects the fast class. Bit 1 reads 0.
- R8: Among the unmasked pending lines of a class, the lowest priority value wins. A tie goes to the highest line number. The winner's line number is latched and read at 0x040 for the normal class and at 0x044 for the fast class.
- R9: An armed class with a candidate raises its output at the next edge and disarms. The output stays high until a write to 0x048 sets bit 0 (normal class) or bit 1 (fast class). That write drops the output and re-arms the class, and the class can raise its output again no earlier than the following edge.
- R10: Bit 2 of 0x048 is the global mask and reads back in bit 2. While it is 1, no output rises.
- R11: Bit 0 of 0x010 is the autoidle bit and reads back. Writing 1 to bit 1 of 0x010 restores the whole R1 state, the line registers included.
- R12: Bits [1:0] of 0x050 are read/write storage. Address 0x04C reads 0.
- R13: Bank index 3 (0x0E0 to 0x0FC) reads 0 and ignores writes. Writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 96 | Level-sensitive interrupt lines, active high |
| reg_addr | input | 12 | Byte address of the register access |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 1 | Normal-class interrupt output |
| fiq_o | output | 1 | Fast-class interrupt output |

## Verification
The assertions assume that every register access is a single-cycle word access on an aligned address. They also assume that the interrupt lines are synchronous to the clock, so that each edge sees exactly one input value. The pending-subset and output-hold properties also rely on soft reset and re-arm writes being the only ways to drop an output. The stimulus drives lines and the bus only at the falling edge. It uses aligned addresses only, includes the invalid bank and the read-only addresses, and keeps soft reset out of the random phase so that the reference model stays in step.

// File: rtl/lvl_intc.sv
module lvl_intc #(
  parameter int NBANK = 3,
  parameter int PRIO_W = 6,
  parameter int ADDR_W = 12,
  parameter logic [7:0] REVISION = 8'h21
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NBANK*32-1:0]   irq_lines,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq_o,
  output logic                  fiq_o
);
  localparam int LW = 32;
  localparam int NLINE = NBANK * LW;
  localparam int CODE_W = $clog2(NLINE);
  localparam logic [ADDR_W-1:0] A_REV  = 'h000;
  localparam logic [ADDR_W-1:0] A_CFG  = 'h010;
  localparam logic [ADDR_W-1:0] A_STAT = 'h014;
  localparam logic [ADDR_W-1:0] A_IRQC = 'h040;
  localparam logic [ADDR_W-1:0] A_FIQC = 'h044;
  localparam logic [ADDR_W-1:0] A_CTRL = 'h048;
  localparam logic [ADDR_W-1:0] A_IDLE = 'h050;
  localparam logic [ADDR_W-1:0] A_LINE = 'h100;
  localparam logic [ADDR_W-1:0] A_LEND = ADDR_W'(256 + 4 * NLINE);

  wire aligned  = reg_addr[1:0] == 2'b00;
  wire bank_hit = aligned && reg_addr[ADDR_W-1:7] == (ADDR_W-7)'(1);
  wire [1:0] bsel = reg_addr[6:5];
  wire [2:0] boff = reg_addr[4:2];
  wire bank_ok  = bank_hit && int'(bsel) < NBANK;
  wire line_hit = aligned && reg_addr >= A_LINE && reg_addr < A_LEND;
  wire [CODE_W-1:0] line_idx = CODE_W'((reg_addr - A_LINE) >> 2);
  wire srst     = reg_we && reg_addr == A_CFG && reg_wdata[1];
  wire ctrl_wr  = reg_we && reg_addr == A_CTRL;
  wire [1:0] rearm = ctrl_wr ? reg_wdata[1:0] : 2'b00;

  logic [NLINE-1:0] in_all, pend_all, mask_all, swi_all, steer;
  logic [PRIO_W-1:0] prio [NLINE];
  logic gmask, autoidle;
  logic [1:0] idle, armed, outq;
  logic [CODE_W-1:0] code [2];
  logic [NLINE-1:0] act [2];
  logic [CODE_W-1:0] win [2];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [LW-1:0] in_q, pend, mask, swi, base;
    wire [LW-1:0] lin = irq_lines[b*LW +: LW];
    wire wsel = reg_we && bank_hit && bsel == 2'(b);
    assign base = |(in_q & ~lin) ? (lin | swi) : (pend | (lin & ~in_q));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q <= '0; pend <= '0; mask <= '1; swi <= '0;
      end else if (srst) begin
        in_q <= '0; pend <= '0; mask <= '1; swi <= '0;
      end else begin
        in_q <= lin;
        pend <= base;
        if (wsel) begin
          case (boff)
            3'd1: mask <= reg_wdata;
            3'd2: mask <= mask & ~reg_wdata;
            3'd3: mask <= mask | reg_wdata;
            3'd4: begin swi <= swi | reg_wdata; pend <= base | reg_wdata; end
            3'd5: begin swi <= swi & ~reg_wdata; pend <= swi & ~reg_wdata & lin; end
            default: ;
          endcase
        end
      end
    end
    assign in_all[b*LW +: LW]   = in_q;
    assign pend_all[b*LW +: LW] = pend;
    assign mask_all[b*LW +: LW] = mask;
    assign swi_all[b*LW +: LW]  = swi;
  end

  function automatic logic [CODE_W-1:0] pick(input logic [NLINE-1:0] cand);
    logic [PRIO_W-1:0] best;
    best = '1;
    pick = '0;
    for (int i = 0; i < NLINE; i++)
      if (cand[i] && prio[i] <= best) begin
        best = prio[i];
        pick = CODE_W'(i);
      end
  endfunction

  assign act[0] = pend_all & ~mask_all & ~steer;
  assign act[1] = pend_all & ~mask_all & steer;
  assign win[0] = pick(act[0]);
  assign win[1] = pick(act[1]);
  assign irq_o = outq[0];
  assign fiq_o = outq[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst) begin
      gmask <= 1'b0; autoidle <= 1'b0; idle <= '0;
      armed <= 2'b11; outq <= 2'b00;
      code[0] <= '0; code[1] <= '0;
      steer <= '0;
      for (int i = 0; i < NLINE; i++) prio[i] <= '0;
    end else begin
      if (reg_we && reg_addr == A_CFG) autoidle <= reg_wdata[0];
      if (ctrl_wr) gmask <= reg_wdata[2];
      if (reg_we && reg_addr == A_IDLE) idle <= reg_wdata[1:0];
      if (reg_we && line_hit) begin
        prio[line_idx]  <= reg_wdata[PRIO_W+1:2];
        steer[line_idx] <= reg_wdata[0];
      end
      for (int c = 0; c < 2; c++) begin
        if (rearm[c]) begin
          outq[c] <= 1'b0;
          armed[c] <= 1'b1;
        end else if (armed[c] && |act[c] && !gmask) begin
          armed[c] <= 1'b0;
          outq[c] <= 1'b1;
          code[c] <= win[c];
        end
      end
    end
  end

  logic [LW-1:0] r_in, r_pend, r_mask, r_swi, r_steer;
  always_comb begin
    r_in = '0; r_pend = '0; r_mask = '0; r_swi = '0; r_steer = '0;
    for (int b = 0; b < NBANK; b++)
      if (int'(bsel) == b) begin
        r_in    = in_all[b*LW +: LW];
        r_pend  = pend_all[b*LW +: LW];
        r_mask  = mask_all[b*LW +: LW];
        r_swi   = swi_all[b*LW +: LW];
        r_steer = steer[b*LW +: LW];
      end
  end

  always_comb begin
    reg_rdata = '0;
    if (bank_hit) begin
      if (bank_ok)
        case (boff)
          3'd0: reg_rdata = r_in;
          3'd1: reg_rdata = r_mask;
          3'd4: reg_rdata = r_swi;
          3'd6: reg_rdata = r_pend & ~r_mask & ~r_steer;
          3'd7: reg_rdata = r_pend & ~r_mask & r_steer;
          default: reg_rdata = '0;
        endcase
    end else if (line_hit) begin
      reg_rdata = 32'({prio[line_idx], 1'b0, steer[line_idx]});
    end else begin
      case (reg_addr)
        A_REV:  reg_rdata = 32'(REVISION);
        A_CFG:  reg_rdata = 32'(autoidle);
        A_STAT: reg_rdata = 32'd1;
        A_IRQC: reg_rdata = 32'(code[0]);
        A_FIQC: reg_rdata = 32'(code[1]);
        A_CTRL: reg_rdata = {29'd0, gmask, 2'b00};
        A_IDLE: reg_rdata = 32'(idle);
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
  parameter int NLINE = 96,
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [CODE_W-1:0] irq_code,
  input logic              gmask,
  input logic [NLINE-1:0]  pend_all,
  input logic [NLINE-1:0]  in_all,
  input logic [NLINE-1:0]  swi_all,
  input logic [1:0]        rearm,
  input logic              srst
);
  assert_pend_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all & ~(in_all | swi_all)) == '0);

  assert_rearm_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm[0] |=> !irq_o);

  assert_rearm_drops_fiq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rearm[1] |=> !fiq_o);

  assert_output_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rearm[0] && !srst) |=> irq_o);

  assert_code_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && $past(irq_o)) |-> $stable(irq_code));

  assert_gmask_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> (!$rose(irq_o) && !$rose(fiq_o)));
endmodule

bind lvl_intc lvl_intc_chk #(.NLINE(NLINE), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .fiq_o(fiq_o),
  .irq_code(code[0]), .gmask(gmask), .pend_all(pend_all),
  .in_all(in_all), .swi_all(swi_all), .rearm(rearm), .srst(srst)
);

// File: tb/test_lvl_intc.sv
module test_lvl_intc;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [95:0] lines = '0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;
  wire  [31:0] rdata;
  wire  irq_o, fiq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_intc i_lvl_intc (.clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_addr(addr),
    .reg_we(we), .reg_wdata(wd), .reg_rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  bit [95:0] m_in, m_pend, m_swi, m_mask, m_steer;
  bit [5:0] m_prio [96];
  bit [1:0] m_arm, m_out, m_idle;
  bit [6:0] m_code [2];
  bit m_gm, m_auto;

  function automatic void m_reset();
    m_in = '0; m_pend = '0; m_swi = '0; m_mask = '1; m_steer = '0;
    for (int i = 0; i < 96; i++) m_prio[i] = '0;
    m_arm = 2'b11; m_out = 2'b00; m_idle = '0;
    m_code[0] = '0; m_code[1] = '0; m_gm = 0; m_auto = 0;
  endfunction

  function automatic int m_pick(bit [95:0] cand);
    int best = 64, w = 0;
    for (int i = 0; i < 96; i++)
      if (cand[i] && int'(m_prio[i]) <= best) begin best = m_prio[i]; w = i; end
    return w;
  endfunction

  function automatic bit [31:0] m_rd(bit [11:0] a);
    int b;
    if (a[1:0] != 0) return 0;
    if (a[11:7] == 5'd1) begin
      b = int'(a[6:5]);
      if (b >= 3) return 0;
      case (a[4:2])
        3'd0: return m_in[b*32 +: 32];
        3'd1: return m_mask[b*32 +: 32];
        3'd4: return m_swi[b*32 +: 32];
        3'd6: return m_pend[b*32 +: 32] & ~m_mask[b*32 +: 32] & ~m_steer[b*32 +: 32];
        3'd7: return m_pend[b*32 +: 32] & ~m_mask[b*32 +: 32] & m_steer[b*32 +: 32];
        default: return 0;
      endcase
    end
    if (a >= 12'h100 && a < 12'h280) begin
      b = int'((a - 12'h100) >> 2);
      return {24'd0, m_prio[b], 1'b0, m_steer[b]};
    end
    case (a)
      12'h000: return 32'h21;
      12'h010: return {31'd0, m_auto};
      12'h014: return 1;
      12'h040: return {25'd0, m_code[0]};
      12'h044: return {25'd0, m_code[1]};
      12'h048: return {29'd0, m_gm, 2'b00};
      12'h050: return {30'd0, m_idle};
      default: return 0;
    endcase
  endfunction

  task automatic m_step();
    bit [95:0] cand;
    int idx;
    if (we && addr == 12'h010 && wd[1]) begin m_reset(); return; end
    for (int c = 0; c < 2; c++) begin
      cand = m_pend & ~m_mask & (c == 1 ? m_steer : ~m_steer);
      if (we && addr == 12'h048 && wd[c]) begin m_out[c] = 0; m_arm[c] = 1; end
      else if (m_arm[c] && cand != 0 && !m_gm) begin
        m_arm[c] = 0; m_out[c] = 1; m_code[c] = 7'(m_pick(cand));
      end
    end
    for (int b = 0; b < 3; b++) begin
      bit [31:0] lin, iq, p, s, k, base;
      lin = lines[b*32 +: 32]; iq = m_in[b*32 +: 32]; p = m_pend[b*32 +: 32];
      s = m_swi[b*32 +: 32]; k = m_mask[b*32 +: 32];
      base = ((iq & ~lin) != 0) ? (lin | s) : (p | (lin & ~iq));
      p = base;
      if (we && addr[11:7] == 5'd1 && int'(addr[6:5]) == b && addr[1:0] == 0)
        case (addr[4:2])
          3'd1: k = wd;
          3'd2: k = k & ~wd;
          3'd3: k = k | wd;
          3'd4: begin s = s | wd; p = base | wd; end
          3'd5: begin s = s & ~wd; p = s & lin; end
          default: ;
        endcase
      m_in[b*32 +: 32] = lin; m_pend[b*32 +: 32] = p;
      m_swi[b*32 +: 32] = s; m_mask[b*32 +: 32] = k;
    end
    if (we && addr == 12'h010) m_auto = wd[0];
    if (we && addr == 12'h048) m_gm = wd[2];
    if (we && addr == 12'h050) m_idle = wd[1:0];
    if (we && addr >= 12'h100 && addr < 12'h280 && addr[1:0] == 0) begin
      idx = int'((addr - 12'h100) >> 2);
      m_prio[idx] = wd[7:2]; m_steer[idx] = wd[0];
    end
  endtask

  function automatic string tag_of(bit [11:0] a);
    if (a[11:7] == 5'd1) begin
      if (a[6:5] == 2'd3) return "R13";
      case (a[4:2])
        3'd0: return "R2";
        3'd1, 3'd2, 3'd3: return "R5";
        3'd4, 3'd5: return "R4";
        default: return "R6";
      endcase
    end
    if (a >= 12'h100 && a < 12'h280) return "R7";
    case (a)
      12'h000, 12'h014: return "R1";
      12'h040, 12'h044: return "R8";
      12'h048: return "R10";
      12'h010: return "R11";
      12'h050: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(string req, bit [31:0] got, bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(bit w, bit [11:0] a, bit [31:0] d);
    we = w; addr = a; wd = d;
    m_step();
    @(posedge clk);
    @(negedge clk);
    chk("R9 irq", {31'd0, irq_o}, {31'd0, m_out[0]});
    chk("R9 fiq", {31'd0, fiq_o}, {31'd0, m_out[1]});
    if (!w) chk(tag_of(a), rdata, m_rd(a));
    we = 0;
  endtask

  task automatic wr(bit [11:0] a, bit [31:0] d); op(1, a, d); endtask
  task automatic rd_exp(bit [11:0] a, bit [31:0] exp, string req);
    op(0, a, 0);
    chk(req, rdata, exp);
  endtask

  function automatic bit [11:0] rnd_addr();
    bit [11:0] fixed [8] = '{12'h000, 12'h010, 12'h014, 12'h040, 12'h044, 12'h048, 12'h04C, 12'h050};
    case ($urandom % 4)
      0: return fixed[$urandom % 8];
      1, 2: return 12'(12'h080 + ($urandom % 4) * 32 + ($urandom % 8) * 4);
      default: return 12'(12'h100 + ($urandom % 96) * 4);
    endcase
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7719));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_exp(12'h000, 32'h21, "R1");
    rd_exp(12'h084, 32'hffffffff, "R1");
    rd_exp(12'h014, 32'd1, "R1");
    rd_exp(12'h048, 32'd0, "R1");
    chk("R1", {31'd0, irq_o}, 0);
    // R5 mask aliases
    wr(12'h084, 32'h0000F0F0);
    wr(12'h088, 32'h000000F0);
    rd_exp(12'h084, 32'h0000F000, "R5");
    wr(12'h08C, 32'h1);
    rd_exp(12'h084, 32'h0000F001, "R5");
    rd_exp(12'h088, 32'h0, "R5");
    // R2 raw inputs, R6, R8 single source, R3 fall
    lines[3] = 1;
    rd_exp(12'h080, 32'h8, "R2");
    rd_exp(12'h098, 32'h8, "R6");
    rd_exp(12'h040, 32'd3, "R8");
    lines[3] = 0;
    rd_exp(12'h098, 32'h0, "R3");
    // R7, R8 tie and priority
    wr(12'h1A0, 32'h08);
    wr(12'h218, 32'h08);
    rd_exp(12'h1A0, 32'h08, "R7");
    wr(12'h1A0 | 12'h000, 32'h0B);
    rd_exp(12'h1A0, 32'h09, "R7");
    wr(12'h1A0, 32'h08);
    wr(12'h0A4, 32'h0);
    wr(12'h0C4, 32'h0);
    lines[40] = 1; lines[70] = 1;
    op(0, 12'h000, 0);
    wr(12'h048, 32'h1);
    chk("R9", {31'd0, irq_o}, 0);
    rd_exp(12'h040, 32'd70, "R8");
    chk("R9", {31'd0, irq_o}, 1);
    wr(12'h1A0, 32'h04);
    wr(12'h048, 32'h1);
    chk("R9", {31'd0, irq_o}, 0);
    rd_exp(12'h040, 32'd40, "R8");
    chk("R9", {31'd0, irq_o}, 1);
    // R10 global mask
    wr(12'h048, 32'h5);
    rd_exp(12'h048, 32'h4, "R10");
    chk("R10", {31'd0, irq_o}, 0);
    op(0, 12'h000, 0);
    chk("R10", {31'd0, irq_o}, 0);
    wr(12'h048, 32'h0);
    rd_exp(12'h040, 32'd40, "R10");
    chk("R10", {31'd0, irq_o}, 1);
    // R6 fast class steering
    wr(12'h1A0, 32'h05);
    rd_exp(12'h0BC, 32'h100, "R6");
    rd_exp(12'h0B8, 32'h0, "R6");
    rd_exp(12'h044, 32'd40, "R6");
    chk("R9", {31'd0, fiq_o}, 1);
    rd_exp(12'h0D8, 32'h40, "R6");
    // R4 software set/clear
    wr(12'h090, 32'h2);
    rd_exp(12'h090, 32'h2, "R4");
    rd_exp(12'h098, 32'h2, "R4");
    wr(12'h094, 32'h2);
    rd_exp(12'h098, 32'h0, "R4");
    rd_exp(12'h090, 32'h0, "R4");
    wr(12'h0D4, 32'h0);
    rd_exp(12'h0D8, 32'h0, "R4");
    // R3 fall keeps software bits
    wr(12'h0D0, 32'h1);
    lines[70] = 0;
    rd_exp(12'h0D8, 32'h1, "R3");
    // R13 invalid bank and read-only writes
    wr(12'h0E4, 32'h0);
    rd_exp(12'h0E4, 32'h0, "R13");
    wr(12'h0F0, 32'hffffffff);
    rd_exp(12'h090, 32'h0, "R13");
    rd_exp(12'h0B0, 32'h0, "R13");
    wr(12'h000, 32'h55);
    rd_exp(12'h000, 32'h21, "R13");
    wr(12'h040, 32'h0);
    rd_exp(12'h040, 32'd40, "R13");
    // R12 idle storage
    wr(12'h050, 32'h7);
    rd_exp(12'h050, 32'h3, "R12");
    rd_exp(12'h04C, 32'h0, "R12");
    // R11 autoidle and soft reset
    wr(12'h010, 32'h1);
    rd_exp(12'h010, 32'h1, "R11");
    wr(12'h010, 32'h2);
    rd_exp(12'h084, 32'hffffffff, "R11");
    rd_exp(12'h010, 32'h0, "R11");
    chk("R11", {30'd0, fiq_o, irq_o}, 0);
    rd_exp(12'h1A0, 32'h0, "R11");
    rd_exp(12'h050, 32'h0, "R11");
    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      int k;
      if ($urandom % 4 == 0) lines[$urandom % 96] ^= 1'b1;
      k = $urandom % 10;
      case (k)
        0, 1, 2, 3: op(0, rnd_addr(), 0);
        4: wr(12'(12'h080 + ($urandom % 4) * 32 + 4 * (1 + $urandom % 3)), $urandom & $urandom);
        5: wr(12'(12'h090 + ($urandom % 4) * 32 + 4 * ($urandom % 2)), 32'h1 << ($urandom % 32));
        6: wr(12'(12'h100 + ($urandom % 96) * 4), $urandom & 32'hFF);
        7: wr(12'h048, {29'd0, ($urandom % 6) == 0, 2'($urandom)});
        8: if ($urandom % 2 == 1) wr(12'h050, $urandom); else wr(12'h010, $urandom & 32'h1);
        default: begin
          bit [11:0] ro [8] = '{12'h000, 12'h014, 12'h040, 12'h044, 12'h080, 12'h098, 12'h09C, 12'h04C};
          wr(ro[$urandom % 8], $urandom);
        end
      endcase
    end
    done = 1;
    summary();
    $finish;
  end
endmodule